// File: doc/BRIEF.md
# SONET A1 Byte-Boundary Aligner

This block sits between a serial bit recovery stage and a downstream SONET/SDH framer. It takes one received bit per bit-clock enable, most significant bit first, collects bits into bytes, and presents each byte with a one-clock valid strobe. The byte boundary is a free-running count of eight bit enables that starts at zero after reset.

The framer owns frame state. When it loses frame it raises the out-of-frame input, and the aligner then compares a 96-bit sliding window against a run of twelve A1 bytes (0xF6 each) at every bit enable, which covers all eight bit phases. On a match the aligner emits the completed A1 byte at once and restarts its byte count, so the bytes that follow, starting with the first A2 byte, arrive aligned. While out-of-frame is low the boundary never moves. A loss-of-carrier input forces the data bits to zero without disturbing the strobe cadence. A2 checking and frame-loss decisions remain with the framer.

Top module: `sonet_a1_aligner`

## Requirements
- R1: While `rst` is high, and on the clock after it, `byte_out` is 0 and `byte_vld` is 0. After reset the bit phase is zero, so the first strobe follows the eighth accepted bit.
- R2: Bits arrive most significant bit first: the first bit accepted in a byte appears on `byte_out[7]`, the last on `byte_out[0]`.
- R3: With no realignment, `byte_vld` pulses for one clock, one clock after the enable that carries every eighth bit. `byte_out` holds the byte during that clock.
- R4: When `oof` is high and the window holding the current bit and the 95 before it equals twelve 0xF6 bytes, a strobe with 0xF6 follows that bit, and every later strobe comes after eight further bits. The following bytes, such as A2 (0x28), therefore come out whole.
- R5: While `oof` is low, the byte boundary never changes, even when the A1 run passes at another bit offset.
- R6: If `oof` stays high after a match on a stable stream, further matches fall on the existing boundary and add no extra strobes.
- R7: On the clock after `carrier_lost` is seen high, `byte_out` is 0, and it stays 0 while the flag is held, including on strobes. The strobe cadence does not change.
- R8: A clock with `bit_en` low accepts no bit, leaves the phase unchanged and yields no strobe on the following clock.
- R9: A run of only eleven 0xF6 bytes does not realign, even with `oof` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable; `bit_in` is taken when high |
| bit_in | input | 1 | Received serial bit |
| oof | input | 1 | Out-of-frame from the framer; enables the A1 hunt |
| carrier_lost | input | 1 | Loss-of-carrier flag; forces data to zero |
| byte_out | output | 8 | Assembled byte, registered |
| byte_vld | output | 1 | One-clock strobe marking a valid byte |

## Verification
The bench places the A1 run three bits off the reset grid and expects one early strobe carrying 0xF6, then A2 bytes on the new grid. A design that compared the stale window or restarted the count one bit late would emit a rotated A2 pattern instead. It also passes the run at a foreign offset with out-of-frame low, and passes an eleven-byte run with it high, where a design that hunted without a request or matched a short window would shift the strobe grid. A long steady A1 stream with the request held checks that repeated matches add no strobes. Loss of carrier must zero the data while the strobe count stays the same; a design that gated the strobe too would drop bytes.

// File: rtl/a1al_pkg.sv
package a1al_pkg;
  parameter int unsigned BYTE_BITS = 8;
  parameter int unsigned A1_RUN    = 12;
  parameter logic [7:0]  A1_CODE   = 8'hF6;

  function automatic int unsigned phase_width(input int unsigned nbits);
    return (nbits <= 2) ? 1 : $clog2(nbits);
  endfunction
endpackage

// File: rtl/a1al_window.sv
module a1al_window #(
  parameter int unsigned WIN = 96
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_en,
  input  logic           bit_in,
  output logic [WIN-1:0] win_q,
  output logic [WIN-1:0] win_nx
);
  // Window as it will be after the current bit; newest bit at index 0.
  assign win_nx = {win_q[WIN-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst)         win_q <= '0;
    else if (bit_en) win_q <= win_nx;
  end
endmodule

// File: rtl/a1al_detect.sv
module a1al_detect #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned RUN_LEN = 12,
  parameter logic [BYTE_W-1:0] PAT = 8'hF6,
  localparam int unsigned WIN = BYTE_W * RUN_LEN
) (
  input  logic [WIN-1:0] win,
  output logic           hit
);
  logic [RUN_LEN-1:0] lane_eq;

  // One comparator per byte lane of the window.
  for (genvar g = 0; g < RUN_LEN; g++) begin : g_lane
    assign lane_eq[g] = (win[g*BYTE_W +: BYTE_W] == PAT);
  end

  assign hit = &lane_eq;
endmodule

// File: rtl/a1al_phase.sv
module a1al_phase #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW = a1al_pkg::phase_width(BYTE_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          realign,
  output logic          byte_end,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  assign byte_end = bit_en && (realign || cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (byte_end) cnt <= '0;
    else if (bit_en)   cnt <= cnt + CW'(1);
  end

  // R8: no bit accepted means the phase does not move
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(cnt));
endmodule

// File: rtl/sonet_a1_aligner.sv
module sonet_a1_aligner #(
  parameter int unsigned BYTE_W  = a1al_pkg::BYTE_BITS,
  parameter int unsigned RUN_LEN = a1al_pkg::A1_RUN,
  parameter logic [BYTE_W-1:0] PAT = BYTE_W'(a1al_pkg::A1_CODE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              oof,
  input  logic              carrier_lost,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  localparam int unsigned WIN = BYTE_W * RUN_LEN;
  localparam int unsigned CW  = a1al_pkg::phase_width(BYTE_W);

  logic [WIN-1:0] win_q, win_nx;
  logic           hit, realign, byte_end;
  logic [CW-1:0]  cnt;

  a1al_window #(.WIN(WIN)) u_window (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .win_q(win_q), .win_nx(win_nx)
  );

  a1al_detect #(.BYTE_W(BYTE_W), .RUN_LEN(RUN_LEN), .PAT(PAT)) u_detect (
    .win(win_nx), .hit(hit)
  );

  // Hunt only on request from the framer.
  assign realign = oof && hit;

  a1al_phase #(.BYTE_W(BYTE_W)) u_phase (
    .clk(clk), .rst(rst), .bit_en(bit_en), .realign(realign),
    .byte_end(byte_end), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= byte_end;
      if (carrier_lost)  byte_out <= '0;
      else if (byte_end) byte_out <= win_nx[BYTE_W-1:0];
    end
  end

  // R7: carrier loss zeroes data on the next clock
  a_r7_carrier_zero: assert property (@(posedge clk) disable iff (rst)
    carrier_lost |=> byte_out == '0);

  // R4: a requested match emits the A1 byte right away
  a_r4_match_emits: assert property (@(posedge clk) disable iff (rst)
    bit_en && oof && hit && !carrier_lost |=> byte_vld && byte_out == PAT);

  // R5: without a request, no strobe off the phase grid
  a_r5_grid_frozen: assert property (@(posedge clk) disable iff (rst)
    bit_en && !oof && cnt != CW'(BYTE_W - 1) |=> !byte_vld);

  // R8: every strobe follows an accepted bit
  a_r8_strobe_needs_bit: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(bit_en));
endmodule

// File: tb/sonet_a1_aligner_test.sv
module sonet_a1_aligner_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       oof = 1'b0;
  logic       carrier_lost = 1'b0;
  logic [7:0] byte_out;
  logic       byte_vld;

  int n_chk = 0;
  int n_bad = 0;
  int bitno = 0;
  int ln = 0;
  int lpos [0:255];
  logic [7:0] ldat [0:255];
  int idle_strobes = 0;

  always #5 clk = ~clk;

  sonet_a1_aligner uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .oof(oof),
    .carrier_lost(carrier_lost), .byte_out(byte_out), .byte_vld(byte_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; oof = 1'b0; carrier_lost = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    bitno = 0; ln = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bitno++;
    if (byte_vld && ln < 256) begin
      lpos[ln] = bitno; ldat[ln] = byte_out; ln++;
    end
    @(negedge clk);
    if (byte_vld) idle_strobes++;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // R1, R2, R3: reset state and first byte on the reset grid
  task automatic t_reset_first();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 byte_out in reset", int'(byte_out), 0);
    check("R1 byte_vld in reset", int'(byte_vld), 0);
    do_reset();
    check("R1 byte_out after reset", int'(byte_out), 0);
    send_byte(8'hA5);
    send_byte(8'h81);
    check("R3 strobe count", ln, 2);
    check("R1 first strobe position", lpos[0], 8);
    check("R2 msb first data", int'(ldat[0]), 'hA5);
    check("R3 second strobe position", lpos[1], 16);
    check("R2 second byte", int'(ldat[1]), 'h81);
  endtask

  // R4: run three bits off grid, then A2 bytes
  task automatic t_align();
    int k;
    do_reset();
    oof = 1'b1;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int i = 0; i < 12; i++) send_byte(8'hF6);
    send_byte(8'h28); send_byte(8'h28); send_byte(8'h55);
    k = 0;
    while (k < ln && lpos[k] <= 96) k++;
    check("R4 strobes after run", ln - k, 4);
    check("R4 match strobe position", lpos[k], 99);
    check("R4 match strobe data", int'(ldat[k]), 'hF6);
    check("R4 first A2 position", lpos[k+1], 107);
    check("R4 first A2 data", int'(ldat[k+1]), 'h28);
    check("R4 second A2 data", int'(ldat[k+2]), 'h28);
    check("R3 trailing byte position", lpos[k+3], 123);
    check("R4 trailing byte data", int'(ldat[k+3]), 'h55);
  endtask

  // R5: continues from t_align; run at foreign offset with oof low
  task automatic t_oof_low();
    int off;
    oof = 1'b0;
    ln = 0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    for (int i = 0; i < 12; i++) send_byte(8'hF6);
    send_byte(8'h28);
    check("R5 strobe count with oof low", ln, 13);
    off = 0;
    for (int i = 0; i < ln; i++) if ((lpos[i] - 123) % 8 != 0) off++;
    check("R5 strobes off old grid", off, 0);
  endtask

  // R6: steady A1 stream, request held high
  task automatic t_stable();
    int off;
    do_reset();
    oof = 1'b1;
    for (int i = 0; i < 24; i++) send_byte(8'hF6);
    send_byte(8'h28);
    check("R6 strobe count stable", ln, 25);
    off = 0;
    for (int i = 0; i < ln; i++) if (lpos[i] != 8 * (i + 1)) off++;
    check("R6 strobes off grid", off, 0);
    check("R6 last byte", int'(ldat[24]), 'h28);
  endtask

  // R9: eleven A1 bytes are not enough
  task automatic t_short();
    int off;
    do_reset();
    oof = 1'b1;
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 0; i < 11; i++) send_byte(8'hF6);
    send_byte(8'h28); send_byte(8'h00);
    check("R9 strobe count short run", ln, 13);
    off = 0;
    for (int i = 0; i < ln; i++) if (lpos[i] % 8 != 0) off++;
    check("R9 strobes off reset grid", off, 0);
  endtask

  // R7: carrier loss zeroes data, keeps cadence
  task automatic t_carrier();
    int nz;
    do_reset();
    send_byte(8'h7E);
    check("R7 byte before loss", int'(ldat[0]), 'h7E);
    @(negedge clk);
    carrier_lost = 1'b1;
    @(negedge clk);
    check("R7 data zero after loss", int'(byte_out), 0);
    ln = 0;
    for (int i = 0; i < 3; i++) send_byte(8'hFF);
    check("R7 cadence kept", ln, 3);
    nz = 0;
    for (int i = 0; i < ln; i++) if (ldat[i] != 8'h00) nz++;
    check("R7 strobed data zero", nz, 0);
    check("R7 position during loss", lpos[2], 32);
    carrier_lost = 1'b0;
    ln = 0;
    send_byte(8'h3C);
    check("R7 data after recovery", int'(ldat[0]), 'h3C);
    check("R7 position after recovery", lpos[0], 40);
  endtask

  initial begin
    t_reset_first();
    t_align();
    t_oof_low();
    t_stable();
    t_short();
    t_carrier();
    check("R8 strobes on idle clocks", idle_strobes, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule